// File: doc/BRIEF.md
# Strip Cluster Width Discriminator

This block receives one binary hit vector from a single strip-sensor layer, one bit per strip. It groups adjacent hit strips into clusters and discards any cluster that is too wide to come from a single high-momentum track. For each cluster it keeps, it sets one bit in a half-strip seed vector. A downstream layer-correlation stage uses that vector to match hits against the second sensor.

Each hit is first qualified against a per-strip disable mask. Runs of qualified hits are then measured. A surviving run of width W that starts at strip s produces its centre at half-strip address 2·s + W − 1. A single strip therefore lands on an even address, a pair lands on the odd address between its two strips, and a triple lands on the even address of its middle strip. The result is captured on a valid strobe, together with a saturating count of the accepted clusters.

Top module: `strip_cluster_filter`

## Requirements
- R1: A strip whose mask bit is 1 is treated as not hit before any clusters are formed. Masking a strip inside a run splits that run into separate clusters.
- R2: Runs of 1, 2 or 3 adjacent qualified strips are accepted, and each one sets exactly one seed bit.
- R3: A run of 4 or more adjacent qualified strips sets no seed bit and is not counted.
- R4: A single hit strip n sets seed bit 2·n.
- R5: A two-strip run on strips n and n+1 sets seed bit 2·n+1, the half-strip midpoint.
- R6: A three-strip run on strips n−1, n and n+1 sets seed bit 2·n, the middle strip.
- R7: A run that touches strip 0 or strip 126 is judged only by the strips it covers inside the range 0..126.
- R8: The seed vector and the count are registered. They update on the clock edge where in_valid is 1, out_valid is high for exactly the following cycle, and both outputs hold their values while in_valid is 0.
- R9: count_o equals the number of accepted clusters, saturating at 2^CNT_W − 1 (31 by default).
- R10: After a synchronous active-low reset, seed_o is 0, count_o is 0 and out_valid is 0.
- R11: Seed bit 253 is never set, and no two adjacent seed bits are ever set together, because distinct clusters are always at least one strip apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: capture the current hit vector |
| hit_i | input | 127 | Binary hit per strip |
| mask_i | input | 127 | Per-strip disable, 1 = strip ignored |
| out_valid | output | 1 | High for the cycle after a capture |
| seed_o | output | 254 | Half-strip cluster centre vector |
| count_o | output | 5 | Saturating count of accepted clusters |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle timing of out_valid and the holding of the outputs between strobes;
- the count being zero exactly when the seed vector is empty;
- the absence of adjacent seed bits and of bit 253.

Other behaviour can only be shown by the bench's scenarios, where a behavioural run-scanning model is compared on every clock:
- the position arithmetic for each cluster width;
- the rejection of wide runs and run splitting by the mask;
- the edge runs and count saturation.

// File: rtl/scd_pkg.sv
// Shared defaults for the strip cluster width discriminator.
// Assumes one sensor layer per instance; geometry is fixed at elaboration.
package scd_pkg;
    localparam int DEF_STRIPS = 127;  // strips per layer
    localparam int DEF_MAX_W  = 3;    // widest accepted cluster
    localparam int DEF_CNT_W  = 5;    // width of the saturating cluster count
endpackage

// File: rtl/scd_hit_qualify.sv
// Qualifies raw hits against the per-strip disable mask.
// Assumes mask bit 1 means the strip is ignored.
module scd_hit_qualify #(
    parameter int N_STRIPS = scd_pkg::DEF_STRIPS
) (
    input  logic [N_STRIPS-1:0] hit_i,
    input  logic [N_STRIPS-1:0] mask_i,
    output logic [N_STRIPS-1:0] clean_o
);
    // Remove disabled strips before clustering.
    always_comb clean_o = hit_i & ~mask_i;
endmodule

// File: rtl/scd_run_locate.sv
// Finds runs of exactly W (1..MAX_W) qualified strips and sets the seed bit
// at half-strip address 2*start + W - 1. Strips outside the layer count as
// unhit, so edge runs are judged by their in-range width.
// Assumes MAX_W <= N_STRIPS.
module scd_run_locate #(
    parameter int N_STRIPS = scd_pkg::DEF_STRIPS,
    parameter int MAX_W    = scd_pkg::DEF_MAX_W
) (
    input  logic [N_STRIPS-1:0]   clean_i,
    output logic [2*N_STRIPS-1:0] seed_o
);
    localparam int SEED_W = 2 * N_STRIPS;
    localparam int PAD_W  = N_STRIPS + 2;
    localparam int ACC_W  = N_STRIPS * MAX_W;

    logic [PAD_W-1:0] padded;
    logic [ACC_W-1:0] exact_run;

    // Pad with one unhit strip on each side so edges need no special case.
    always_comb padded = {1'b0, clean_i, 1'b0};

    // One detector per (start strip, width) pair that fits inside the layer.
    for (genvar s = 0; s < N_STRIPS; s++) begin : g_start
        for (genvar w = 1; w <= MAX_W; w++) begin : g_width
            if (s + w <= N_STRIPS) begin : g_fit
                assign exact_run[s*MAX_W + w - 1] =
                    (&padded[s+w:s+1]) & ~padded[s] & ~padded[s+w+1];
            end else begin : g_nofit
                assign exact_run[s*MAX_W + w - 1] = 1'b0;
            end
        end
    end

    // Map each accepted run onto its half-strip centre.
    always_comb begin
        seed_o = '0;
        for (int s = 0; s < N_STRIPS; s++) begin
            for (int w = 1; w <= MAX_W; w++) begin
                if (s + w <= N_STRIPS) begin
                    seed_o[2*s + w - 1] = seed_o[2*s + w - 1] | exact_run[s*MAX_W + w - 1];
                end
            end
        end
    end

    logic unused_top;
    always_comb unused_top = seed_o[SEED_W-1];
endmodule

// File: rtl/scd_seed_count.sv
// Counts set seed bits (one per accepted cluster) and saturates the total
// to the output width. Assumes each cluster contributes exactly one bit.
module scd_seed_count #(
    parameter int SEED_W = 2 * scd_pkg::DEF_STRIPS,
    parameter int CNT_W  = scd_pkg::DEF_CNT_W
) (
    input  logic [SEED_W-1:0] seed_i,
    output logic [CNT_W-1:0]  count_o
);
    localparam int TOT_W = $clog2(SEED_W + 1);
    localparam logic [TOT_W-1:0] SAT = TOT_W'((1 << CNT_W) - 1);

    logic [TOT_W-1:0] total;

    // Population count of the seed vector.
    always_comb begin
        total = '0;
        for (int i = 0; i < SEED_W; i++) total = total + TOT_W'(seed_i[i]);
    end

    // Clamp at the largest representable count.
    always_comb count_o = (total > SAT) ? CNT_W'(SAT) : CNT_W'(total);
endmodule

// File: rtl/strip_cluster_filter.sv
// Top: qualifies hits, keeps clusters up to MAX_W strips wide, marks their
// half-strip centres and registers the result one cycle after in_valid.
// Assumes a synchronous active-low reset and one layer per instance.
module strip_cluster_filter #(
    parameter int N_STRIPS = scd_pkg::DEF_STRIPS,
    parameter int MAX_W    = scd_pkg::DEF_MAX_W,
    parameter int CNT_W    = scd_pkg::DEF_CNT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [N_STRIPS-1:0]   hit_i,
    input  logic [N_STRIPS-1:0]   mask_i,
    output logic                  out_valid,
    output logic [2*N_STRIPS-1:0] seed_o,
    output logic [CNT_W-1:0]      count_o
);
    localparam int SEED_W = 2 * N_STRIPS;

    logic [N_STRIPS-1:0] clean;
    logic [SEED_W-1:0]   seed_d;
    logic [CNT_W-1:0]    count_d;

    scd_hit_qualify #(.N_STRIPS(N_STRIPS)) u_qual (
        .hit_i  (hit_i),
        .mask_i (mask_i),
        .clean_o(clean)
    );

    scd_run_locate #(.N_STRIPS(N_STRIPS), .MAX_W(MAX_W)) u_runs (
        .clean_i(clean),
        .seed_o (seed_d)
    );

    scd_seed_count #(.SEED_W(SEED_W), .CNT_W(CNT_W)) u_count (
        .seed_i (seed_d),
        .count_o(count_d)
    );

    // Capture the result on the strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            seed_o    <= '0;
            count_o   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                seed_o  <= seed_d;
                count_o <= count_d;
            end
        end
    end

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(seed_o) && $stable(count_o)));
    // R9
    count_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0) == (seed_o == '0));
    // R11
    no_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_o & (seed_o >> 1)) == '0);
    // R11
    top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seed_o[SEED_W-1]);
endmodule

// File: tb/tb_strip_cluster_filter.sv
`timescale 1ns/1ps
module tb_strip_cluster_filter;
    localparam int N  = 127;
    localparam int SW = 254;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [N-1:0]  hit_i = '0;
    logic [N-1:0]  mask_i = '0;
    logic          out_valid;
    logic [SW-1:0] seed_o;
    logic [CW-1:0] count_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;
    string tag = "R10";

    logic          exp_valid = 1'b0;
    logic [SW-1:0] exp_seed = '0;
    int            exp_count = 0;

    strip_cluster_filter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hit_i(hit_i),
        .mask_i(mask_i), .out_valid(out_valid), .seed_o(seed_o), .count_o(count_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string t, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // Behavioural reference: scan runs left to right.
    function automatic void ref_model(input logic [N-1:0] h, input logic [N-1:0] m,
                                      output logic [SW-1:0] s, output int c);
        int i, st, w;
        s = '0; c = 0; i = 0;
        while (i < N) begin
            if (h[i] && !m[i]) begin
                st = i;
                while (i < N && h[i] && !m[i]) i++;
                w = i - st;
                if (w <= 3) begin
                    s[2*st + w - 1] = 1'b1;
                    c++;
                end
            end else begin
                i++;
            end
        end
        if (c > 31) c = 31;
    endfunction

    // Reference state advances on the same edges as the design.
    always @(posedge clk) begin
        logic [SW-1:0] s;
        int c;
        started <= 1'b1;
        if (!rst_n) begin
            exp_valid <= 1'b0; exp_seed <= '0; exp_count <= 0;
        end else begin
            exp_valid <= in_valid;
            if (in_valid) begin
                ref_model(hit_i, mask_i, s, c);
                exp_seed <= s; exp_count <= c;
            end
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(out_valid == exp_valid, {tag, " R8 valid"}, 256'(out_valid), 256'(exp_valid));
            chk(seed_o == exp_seed, {tag, " seed"}, 256'(seed_o), 256'(exp_seed));
            chk(int'(count_o) == exp_count, {tag, " R9 count"}, 256'(count_o), 256'(exp_count));
        end
    end

    task automatic apply(input logic [N-1:0] h, input logic [N-1:0] m, input string t);
        @(negedge clk);
        tag = t; hit_i = h; mask_i = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [N-1:0] strips(input int a, input int b);
        logic [N-1:0] v = '0;
        for (int i = a; i <= b; i++) v[i] = 1'b1;
        return v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(seed_o == '0 && count_o == '0 && !out_valid, "R10 reset", 256'(seed_o), 256'(0));
        rst_n = 1'b1;

        apply(strips(10, 10), '0, "R4");
        chk(seed_o[20] && count_o == 1, "R4 single at 10", 256'(seed_o), 256'(1) << 20);
        apply(strips(40, 41), '0, "R5");
        chk(seed_o[81] && count_o == 1, "R5 pair 40-41", 256'(seed_o), 256'(1) << 81);
        apply(strips(60, 62), '0, "R6");
        chk(seed_o[122] && count_o == 1, "R6 triple 60-62", 256'(seed_o), 256'(1) << 122);
        apply(strips(80, 83), '0, "R3");
        chk(seed_o == '0 && count_o == 0, "R3 run of 4", 256'(seed_o), 256'(0));
        apply('1, '0, "R3");
        chk(seed_o == '0, "R3 all strips hit", 256'(seed_o), 256'(0));
        apply(strips(10, 10) | strips(40, 41) | strips(60, 62), '0, "R2");
        chk(count_o == 3 && seed_o[20] && seed_o[81] && seed_o[122], "R2 widths 1,2,3",
            256'(count_o), 256'(3));
        apply(strips(60, 62), strips(62, 62), "R1");
        chk(seed_o[121] && count_o == 1, "R1 masked end", 256'(seed_o), 256'(1) << 121);
        apply(strips(80, 83), strips(81, 81), "R1");
        chk(seed_o[160] && seed_o[165] && count_o == 2, "R1 masked split",
            256'(seed_o), (256'(1) << 160) | (256'(1) << 165));
        apply(strips(0, 1), '0, "R7");
        chk(seed_o[1] && count_o == 1, "R7 low edge pair", 256'(seed_o), 256'(2));
        apply(strips(124, 126), '0, "R7");
        chk(seed_o[250] && count_o == 1, "R7 high edge triple", 256'(seed_o), 256'(1) << 250);
        apply(strips(126, 126), '0, "R7");
        chk(seed_o[252] && count_o == 1, "R7 last strip", 256'(seed_o), 256'(1) << 252);
        apply(strips(123, 126), '0, "R7");
        chk(seed_o == '0, "R7 wide edge run", 256'(seed_o), 256'(0));
        apply(strips(20, 20) | strips(22, 22), '0, "R11");
        chk(seed_o[40] && seed_o[44] && count_o == 2, "R11 close singles",
            256'(seed_o), (256'(1) << 40) | (256'(1) << 44));
        begin
            logic [N-1:0] ev = '0;
            for (int i = 0; i < N; i += 2) ev[i] = 1'b1;
            apply(ev, '0, "R9");
            chk(count_o == 31, "R9 saturation", 256'(count_o), 256'(31));
        end
        // Hold: inputs change with the strobe low.
        @(negedge clk);
        tag = "R8"; hit_i = strips(5, 5); mask_i = '0;
        repeat (3) @(negedge clk);
        chk(count_o == 31 && !out_valid, "R8 hold", 256'(count_o), 256'(31));

        for (int k = 0; k < 400; k++) begin
            logic [N-1:0] h, m;
            for (int j = 0; j < N; j++) begin
                h[j] = ($urandom % 100) < (k % 2 ? 30 : 60);
                m[j] = ($urandom % 100) < 8;
            end
            apply(h, (k % 3 == 0) ? m : '0, "R2 random");
            if (k % 5 == 0) repeat (2) @(negedge clk);
        end
        tag = "R10";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(seed_o == '0 && count_o == 0 && !out_valid, "R10 reset again", 256'(seed_o), 256'(0));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule